// File: doc/BRIEF.md
# Frame Skew Meter

This block finds how late a frame-evaluation signal arrives compared with the local frame pulse, so that software can later program skew compensation for an input stream. It runs on a sampling clock at twice the master rate, so one clock cycle is half a master period. The result is given in those half-period units.

Software first holds the start control low for at least one whole frame, which arms the unit. It then raises the start control. The unit waits for the next frame boundary and counts cycles until the evaluation signal shows the matching edge. At the frame boundary after that, it latches the count and raises a completion flag. That happens two frame boundaries after the start. A mode input chooses the edge convention. A wide-frame-pulse mode input turns the whole function off.

Top module: `frame_skew_meter`

## Requirements
- R1: While reset is asserted and right after it, `done_o` is 0 and `offset_o` is 0.
- R2: A rising edge on `start_bit` starts a measurement only if `start_bit` was low for at least FRAME_LEN consecutive cycles just before it. Any other rising edge is ignored, and no completion follows it.
- R3: With `rising_mode`=0, a frame boundary is a 1-to-0 change of `frm_pulse` and the evaluation edge is a 1-to-0 change of `eval_in`. With `rising_mode`=1, both are 0-to-1 changes. No edge is recognised in the first cycle after reset.
- R4: The result is the number of cycles from the first frame boundary after the start to the first evaluation edge after it. It is 0 when both fall in the same cycle.
- R5: `done_o` rises in the cycle after the second frame boundary that follows an accepted start.
- R6: If no evaluation edge occurs before the second frame boundary, `offset_o` becomes all ones (4095 for a 12-bit result) and `done_o` still rises. An evaluation edge in the same cycle as that boundary does not count.
- R7: `done_o` returns to 0 in the cycle after `start_bit` goes low. `offset_o` keeps its value.
- R8: While `wide_fp_mode` is 1, no measurement runs, `done_o` stays 0, and the arming time restarts.
- R9: If `start_bit` goes low before completion, the measurement is abandoned and no completion follows.
- R10: `offset_o` changes only in the cycle where `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, twice the master rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_pulse | input | 1 | Local frame pulse |
| eval_in | input | 1 | Frame-evaluation signal to be measured |
| start_bit | input | 1 | Arm (held low) and start (rising) control |
| rising_mode | input | 1 | Edge convention: 1 = rising edges, 0 = falling edges |
| wide_fp_mode | input | 1 | Disables the function when 1 |
| offset_o | output | OFS_W (12) | Measured offset, in half master periods |
| done_o | output | 1 | Completion flag |

## Verification
The assertions assume that `frm_pulse` shows its boundary edge once every FRAME_LEN cycles. Under that assumption a completed result is either below FRAME_LEN or saturated. The stimulus makes the frame pulse and the evaluation signal as two-cycle pulses from one free-running phase counter with period FRAME_LEN, with the evaluation pulse shifted by a chosen delay. Mode changes happen only while the start control is low, so each measurement window sees one steady edge convention.

// File: rtl/skew_pkg.sv
package skew_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MEAS = 2'd2,
    ST_DONE = 2'd3
  } meas_st_e;
endpackage

// File: rtl/skew_edge_det.sv
module skew_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic rising_sel,
  output logic edge_o
);
  logic prev_q, vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= sig_i;
      vld_q  <= 1'b1;
    end
  end

  always_comb begin
    edge_o = vld_q && (rising_sel ? (sig_i && !prev_q) : (!sig_i && prev_q));
  end
endmodule

// File: rtl/skew_arm.sv
module skew_arm #(
  parameter int FRAME_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_bit,
  input  logic wide_mode,
  output logic go_o
);
  localparam int LW = $clog2(FRAME_LEN + 1);

  logic [LW-1:0] low_cnt_q, low_cnt_d;
  logic          start_q;
  logic          armed;

  always_comb begin
    low_cnt_d = low_cnt_q;
    if (start_bit || wide_mode)
      low_cnt_d = '0;
    else if (low_cnt_q != LW'(FRAME_LEN))
      low_cnt_d = low_cnt_q + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      start_q   <= 1'b0;
    end else begin
      low_cnt_q <= low_cnt_d;
      start_q   <= start_bit;
    end
  end

  assign armed = (low_cnt_q == LW'(FRAME_LEN));
  assign go_o  = start_bit && !start_q && armed && !wide_mode;

  // R2: an accepted start follows a cycle with the control low
  p_go_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> $past(!start_bit));
endmodule

// File: rtl/skew_meas.sv
module skew_meas
  import skew_pkg::*;
#(
  parameter int FRAME_LEN = 1024,
  parameter int OFS_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             fp_edge,
  input  logic             ev_edge,
  input  logic             start_bit,
  input  logic             wide_mode,
  output logic [OFS_W-1:0] offset_o,
  output logic             done_o
);
  meas_st_e           st_q, st_d;
  logic [OFS_W-1:0]   cnt_q, cnt_d, res_q, res_d, ofs_q, ofs_d;
  logic               got_q, got_d, done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    res_d  = res_q;
    got_d  = got_q;
    ofs_d  = ofs_q;
    done_d = done_q;
    if (wide_mode || !start_bit) begin
      st_d   = ST_IDLE;
      done_d = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (go_i) st_d = ST_WAIT;
        ST_WAIT: begin
          if (fp_edge) begin
            cnt_d = OFS_W'(1);
            got_d = ev_edge;
            res_d = '0;
            st_d  = ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (fp_edge) begin
            st_d   = ST_DONE;
            done_d = 1'b1;
            ofs_d  = got_q ? res_q : '1;
          end else begin
            if (ev_edge && !got_q) begin
              res_d = cnt_q;
              got_d = 1'b1;
            end
            if (cnt_q != '1) cnt_d = cnt_q + OFS_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      res_q  <= '0;
      got_q  <= 1'b0;
      ofs_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      res_q  <= res_d;
      got_q  <= got_d;
      ofs_q  <= ofs_d;
      done_q <= done_d;
    end
  end

  assign offset_o = ofs_q;
  assign done_o   = done_q;

  p_done_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_bit |=> !done_o);
  p_wide_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode |=> !done_o);
  p_done_on_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(fp_edge));
  p_ofs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done_o) |-> $stable(offset_o));
  p_ofs_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (offset_o < OFS_W'(FRAME_LEN) || offset_o == '1));
endmodule

// File: rtl/frame_skew_meter.sv
module frame_skew_meter #(
  parameter int FRAME_LEN = 1024,
  parameter int OFS_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_pulse,
  input  logic             eval_in,
  input  logic             start_bit,
  input  logic             rising_mode,
  input  logic             wide_fp_mode,
  output logic [OFS_W-1:0] offset_o,
  output logic             done_o
);
  localparam int NSIG = 2;

  logic [NSIG-1:0] sig_vec, edge_vec;
  logic            go;

  assign sig_vec = {eval_in, frm_pulse};

  for (genvar g = 0; g < NSIG; g++) begin : g_edge
    skew_edge_det u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .sig_i      (sig_vec[g]),
      .rising_sel (rising_mode),
      .edge_o     (edge_vec[g])
    );
  end

  skew_arm #(.FRAME_LEN(FRAME_LEN)) u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_bit (start_bit),
    .wide_mode (wide_fp_mode),
    .go_o      (go)
  );

  skew_meas #(.FRAME_LEN(FRAME_LEN), .OFS_W(OFS_W)) u_meas (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go),
    .fp_edge   (edge_vec[0]),
    .ev_edge   (edge_vec[1]),
    .start_bit (start_bit),
    .wide_mode (wide_fp_mode),
    .offset_o  (offset_o),
    .done_o    (done_o)
  );

  // R1: outputs come out of reset cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!done_o && offset_o == '0) || !rst_n);
endmodule

// File: tb/sim_frame_skew_meter.sv
module sim_frame_skew_meter;
  localparam int FL = 64;

  logic clk = 1'b0;
  logic rst_n, fp, ev, start, mode, wide;
  logic [11:0] ofs;
  logic done;

  int checks = 0, fails = 0;
  int ph = 0, dly = 0;
  bit noev = 1'b0, finished = 1'b0;

  // reference model state
  int m_low, m_phase, m_cnt, m_res, m_ofs;
  bit m_got, m_done, m_valid, m_fpp, m_evp, m_stp;

  always #2.5 clk = ~clk;

  frame_skew_meter #(.FRAME_LEN(FL), .OFS_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_pulse(fp), .eval_in(ev), .start_bit(start),
    .rising_mode(mode), .wide_fp_mode(wide), .offset_o(ofs), .done_o(done)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_low = 0; m_phase = 0; m_cnt = 0; m_res = 0; m_ofs = 0;
      m_got = 0; m_done = 0; m_valid = 0; m_fpp = 0; m_evp = 0; m_stp = 0;
    end else begin
      bit fe, ee, rise;
      fe = m_valid && (mode ? (fp && !m_fpp) : (!fp && m_fpp));
      ee = m_valid && (mode ? (ev && !m_evp) : (!ev && m_evp));
      rise = start && !m_stp;
      if (wide || !start) begin
        m_phase = 0; m_done = 0;
      end else if (m_phase == 0) begin
        if (rise && m_low == FL) m_phase = 1;
      end else if (m_phase == 1) begin
        if (fe) begin m_cnt = 1; m_got = ee; m_res = 0; m_phase = 2; end
      end else if (m_phase == 2) begin
        if (fe) begin
          m_done = 1; m_ofs = m_got ? m_res : 4095; m_phase = 3;
        end else begin
          if (ee && !m_got) begin m_res = m_cnt; m_got = 1; end
          if (m_cnt < 4095) m_cnt++;
        end
      end
      if (start || wide) m_low = 0; else if (m_low < FL) m_low++;
      m_fpp = fp; m_evp = ev; m_stp = start; m_valid = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      chk(done == m_done, "R5 model done", done, m_done);
      chk(ofs == m_ofs[11:0], "R4 model offset", ofs, m_ofs);
    end
    ph = (ph + 1) % FL;
    begin
      bit fpul, epul;
      fpul = ph < 2;
      epul = ((ph - dly + FL) % FL) < 2;
      fp = mode ? fpul : !fpul;
      ev = noev ? !mode : (mode ? epul : !epul);
    end
  endtask

  task automatic measure(input bit m, input int d, input bit ne, input int exp, input string req);
    mode = m; dly = d; noev = ne; start = 0;
    repeat (FL + 3) tick();
    start = 1;
    repeat (2 * FL + 4) tick();
    chk(done == 1'b1, "R5 completion", done, 1);
    chk(ofs == exp[11:0], req, ofs, exp);
    start = 0;
    tick();
    chk(done == 1'b0, "R7 done clears", done, 0);
    chk(ofs == exp[11:0], "R7 offset held", ofs, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; mode = 1; wide = 0; fp = 0; ev = 0;
    repeat (4) tick();
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(ofs == 12'd0, "R1 reset offset", ofs, 0);
    rst_n = 1;
    tick();
    chk(done == 1'b0 && ofs == 12'd0, "R1 after release", ofs, 0);

    measure(1, 7, 0, 7, "R4 rising delay 7");
    measure(1, 0, 0, 0, "R4 same cycle");
    measure(0, 13, 0, 13, "R3 falling delay 13");
    measure(1, FL - 1, 0, FL - 1, "R4 last slot");
    measure(0, 5, 1, 4095, "R6 saturate");

    // R2: start raised after too short a low time
    start = 0; repeat (FL / 2) tick();
    start = 1; repeat (2 * FL + 4) tick();
    chk(done == 1'b0, "R2 not armed", done, 0);

    // R9: abort mid measurement
    mode = 1; dly = 9; noev = 0;
    start = 0; repeat (FL + 3) tick();
    start = 1; repeat (FL + FL / 2) tick();
    start = 0; tick();
    start = 1; repeat (2 * FL + 4) tick();
    chk(done == 1'b0, "R9 abort", done, 0);

    // R8: wide mode blocks
    start = 0; wide = 1; repeat (FL + 3) tick();
    start = 1; repeat (2 * FL + 4) tick();
    chk(done == 1'b0, "R8 wide mode", done, 0);
    wide = 0;

    // R10: offset holds during a new measurement
    measure(1, 7, 0, 7, "R4 repeat 7");
    dly = 20; start = 0; repeat (FL + 3) tick();
    start = 1; repeat (FL) tick();
    chk(ofs == 12'd7, "R10 offset held mid run", ofs, 7);
    repeat (FL + 4) tick();
    chk(ofs == 12'd20 && done, "R10 offset updated", ofs, 20);
    start = 0; tick();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule